// File: doc/BRIEF.md
# SDRAM Worst-Case Burst Access Sequencer

This block runs one complete access to a single 16-bit SDRAM chip on the assumption that nothing about the previous access can be reused. A request names a bank, a row, a starting column and a direction. The sequencer closes every bank, opens the requested row, and issues one read or write that carries auto-precharge. The burst is eight words. For a write, the eight words come from the request. For a read, the eight words the device returns are captured and handed back one per clock.

The block suits a memory controller that has to bound its worst-case latency. The sequence is always the same length: a read holds the block for 23 clocks and a write for 21. With the default timing the command spacing is fixed: 3 clocks from close-all to open-row, and 10 clocks from open-row to the column command. The open-to-column spacing is a parameter that may be set from 3 to 10. Device power-up, refresh and pad timing are handled elsewhere.

The state machine has nine states:

| State | What happens in it |
|---|---|
| ST_IDLE | waits for a request |
| ST_PRE | issues close-all |
| ST_TRP | waits out the precharge spacing |
| ST_ACT | opens the row |
| ST_TRCD | waits out the activate spacing |
| ST_COL | issues the read or write |
| ST_CAS | waits out the read latency |
| ST_RDAT | the eight read beats |
| ST_WDAT | the remaining seven write beats |

Transitions:
- IDLE→PRE when a request is presented.
- PRE→TRP always.
- TRP→ACT when the wait counter expires.
- ACT→TRCD always.
- TRCD→COL when the counter expires.
- COL→WDAT for a write, or COL→CAS for a read.
- CAS→RDAT when the counter expires.
- RDAT→IDLE and WDAT→IDLE when the counter expires.

Top module: `sdram_burst_seq`

## Requirements
- R1: While reset is held and after it is released, the block drives NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1). In that state busy, sd_dq_oe and rd_valid are all low.
- R2: A request is accepted on a rising edge only when req_valid is high and busy is low. Once accepted, busy is high in the next cycle. A request pulsed while busy is ignored: no second activate follows.
- R3: The first command after acceptance is precharge-all (0,0,1,0) with address bit 10 high. It is issued in the first busy cycle. The activate follows exactly T_RP = 3 clocks later.
- R4: The activate (0,0,1,1) drives the request's bank on sd_ba and its row on sd_addr. The column command follows exactly T_RCD clocks later. T_RCD is a parameter from 3 to 10 and defaults to 10.
- R5: The column command is read (0,1,0,1) or write (0,1,0,0), according to req_write. It carries the column on the low address bits and address bit 10 high, which selects auto-precharge.
- R6: Read data is sampled from sd_dq_in for 8 consecutive clocks. Sampling starts 2 clocks after the read command (CAS latency 2).
- R7: The captured read words appear on rd_data with rd_valid high for 8 consecutive cycles, in burst order. The first appears 3 cycles after the read command cycle. rd_done is high together with the eighth word only.
- R8: A write drives sd_dq_oe high for exactly 8 cycles, starting in the write command cycle. Beat k carries req_wdata[16k+15:16k].
- R9: busy stays high from the cycle after acceptance through the last data word on the SDRAM bus. That is 23 cycles for a read and 21 for a write.
- R10: Every cycle that issues no command drives NOP. Only the NOP, precharge, activate, read and write encodings ever appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | request present |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_bank | input | 2 | target bank |
| req_row | input | 13 | target row |
| req_col | input | 9 | starting column |
| req_wdata | input | 128 | eight write words, word k in bits [16k+15:16k] |
| busy | output | 1 | access in progress |
| rd_valid | output | 1 | rd_data holds a returned word |
| rd_data | output | 16 | returned read word |
| rd_done | output | 1 | final word of the read burst |
| sd_cs_n | output | 1 | chip select, active low |
| sd_ras_n | output | 1 | row strobe, active low |
| sd_cas_n | output | 1 | column strobe, active low |
| sd_we_n | output | 1 | write enable, active low |
| sd_ba | output | 2 | bank address |
| sd_addr | output | 13 | multiplexed address |
| sd_dq_out | output | 16 | write data to the device |
| sd_dq_oe | output | 1 | data bus drive enable |
| sd_dq_in | input | 16 | read data from the device |

## Verification
On every cycle, the assertions check the following:
- the command encoding is legal;
- NOP is driven whenever the block is idle;
- address bit 10 is high on precharge and column commands;
- the precharge-to-activate and activate-to-column spacing is exact;
- the data drive is confined to busy cycles;
- rd_done ends a run of exactly eight valid words.

Only the bench scenarios can show the remaining behaviour. That covers the data itself: written words reaching the right beat, read words returning in order and in the right cycle, and the bank, row and column reaching the bus. The scenarios also show the exact busy length per direction and that a request arriving mid-access is dropped.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_TRP,
        ST_ACT,
        ST_TRCD,
        ST_COL,
        ST_CAS,
        ST_RDAT,
        ST_WDAT
    } seq_state_t;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_PRECHARGE,
        CMD_ACTIVATE,
        CMD_READ,
        CMD_WRITE
    } sd_cmd_t;

    // control pin order: cs_n, ras_n, cas_n, we_n
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_pins_t;

    localparam int PRECHARGE_AP_BIT = 10;

endpackage

// File: rtl/sbs_cmd_enc.sv
module sbs_cmd_enc
    import sbs_pkg::*;
(
    input  sd_cmd_t  cmd,
    output sd_pins_t pins
);

    always_comb begin
        unique case (cmd)
            CMD_PRECHARGE: pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            CMD_ACTIVATE:  pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
            CMD_READ:      pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
            CMD_WRITE:     pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
            default:       pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
    end

endmodule

// File: rtl/sbs_wait_cnt.sv
module sbs_wait_cnt #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count   = cnt_q;
    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sbs_rd_capture.sv
module sbs_rd_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              cap_last,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_done
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_done  <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= cap_en;
            rd_done  <= cap_en & cap_last;
            if (cap_en) begin
                rd_data <= dq_in;
            end
        end
    end

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sbs_pkg::*;
#(
    parameter int BANK_W  = 2,
    parameter int ROW_W   = 13,
    parameter int COL_W   = 9,
    parameter int DATA_W  = 16,
    parameter int BURST   = 8,
    parameter int T_RP    = 3,
    parameter int T_RCD   = 10,
    parameter int CAS_LAT = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [BANK_W-1:0]       req_bank,
    input  logic [ROW_W-1:0]        req_row,
    input  logic [COL_W-1:0]        req_col,
    input  logic [BURST*DATA_W-1:0] req_wdata,
    output logic                    busy,
    output logic                    rd_valid,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    rd_done,
    output logic                    sd_cs_n,
    output logic                    sd_ras_n,
    output logic                    sd_cas_n,
    output logic                    sd_we_n,
    output logic [BANK_W-1:0]       sd_ba,
    output logic [ROW_W-1:0]        sd_addr,
    output logic [DATA_W-1:0]       sd_dq_out,
    output logic                    sd_dq_oe,
    input  logic [DATA_W-1:0]       sd_dq_in
);

    localparam int WDATA_W = BURST * DATA_W;
    localparam int LONGEST = (T_RCD > BURST) ? T_RCD : BURST;
    localparam int CNT_W   = $clog2(LONGEST + T_RP + CAS_LAT) + 1;
    localparam int BEAT_W  = $clog2(BURST);

    seq_state_t state_q, state_d;

    logic               wr_q;
    logic [BANK_W-1:0]  bank_q;
    logic [ROW_W-1:0]   row_q;
    logic [COL_W-1:0]   col_q;
    logic [WDATA_W-1:0] wdata_q;

    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic [CNT_W-1:0]   tmr_count;
    logic               tmr_done;

    sd_cmd_t            cmd;
    sd_pins_t           pins;
    logic [BEAT_W-1:0]  beat;
    logic               cap_en;
    logic               cap_last;

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
            bank_q  <= '0;
            row_q   <= '0;
            col_q   <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                wr_q    <= req_write;
                bank_q  <= req_bank;
                row_q   <= req_row;
                col_q   <= req_col;
                wdata_q <= req_wdata;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_PRE;
            ST_PRE:  state_d = ST_TRP;
            ST_TRP:  if (tmr_done) state_d = ST_ACT;
            ST_ACT:  state_d = ST_TRCD;
            ST_TRCD: if (tmr_done) state_d = ST_COL;
            ST_COL:  state_d = wr_q ? ST_WDAT : ST_CAS;
            ST_CAS:  if (tmr_done) state_d = ST_RDAT;
            ST_RDAT: if (tmr_done) state_d = ST_IDLE;
            ST_WDAT: if (tmr_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // wait lengths: a state that lasts N cycles is loaded with N-1 on entry
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_TRP:  tmr_val = CNT_W'(T_RP - 2);
            ST_TRCD: tmr_val = CNT_W'(T_RCD - 2);
            ST_CAS:  tmr_val = CNT_W'(CAS_LAT - 2);
            ST_RDAT: tmr_val = CNT_W'(BURST - 1);
            ST_WDAT: tmr_val = CNT_W'(BURST - 2);
            default: tmr_val = '0;
        endcase
    end

    sbs_wait_cnt #(
        .CNT_W (CNT_W)
    ) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .count    (tmr_count),
        .expired  (tmr_done)
    );

    assign beat = (state_q == ST_WDAT)
                ? BEAT_W'(BURST - 1) - tmr_count[BEAT_W-1:0]
                : '0;

    // outputs
    always_comb begin
        cmd       = CMD_NOP;
        sd_ba     = '0;
        sd_addr   = '0;
        sd_dq_oe  = 1'b0;
        sd_dq_out = '0;
        unique case (state_q)
            ST_PRE: begin
                cmd                       = CMD_PRECHARGE;
                sd_addr[PRECHARGE_AP_BIT] = 1'b1;
            end
            ST_ACT: begin
                cmd     = CMD_ACTIVATE;
                sd_ba   = bank_q;
                sd_addr = row_q;
            end
            ST_COL: begin
                cmd                       = wr_q ? CMD_WRITE : CMD_READ;
                sd_ba                     = bank_q;
                sd_addr[COL_W-1:0]        = col_q;
                sd_addr[PRECHARGE_AP_BIT] = 1'b1;
                sd_dq_oe                  = wr_q;
                sd_dq_out                 = wr_q ? wdata_q[DATA_W-1:0] : '0;
            end
            ST_WDAT: begin
                sd_dq_oe  = 1'b1;
                sd_dq_out = wdata_q[beat*DATA_W +: DATA_W];
            end
            default: begin
                cmd = CMD_NOP;
            end
        endcase
    end

    sbs_cmd_enc u_enc (
        .cmd  (cmd),
        .pins (pins)
    );

    assign sd_cs_n  = pins.cs_n;
    assign sd_ras_n = pins.ras_n;
    assign sd_cas_n = pins.cas_n;
    assign sd_we_n  = pins.we_n;
    assign busy     = (state_q != ST_IDLE);

    assign cap_en   = (state_q == ST_RDAT);
    assign cap_last = tmr_done;

    sbs_rd_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_last (cap_last),
        .dq_in    (sd_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_done  (rd_done)
    );

endmodule

// File: rtl/sbs_chk.sv
module sbs_chk #(
    parameter int ROW_W = 13,
    parameter int BURST = 8,
    parameter int T_RP  = 3,
    parameter int T_RCD = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             rd_valid,
    input logic             rd_done,
    input logic             sd_cs_n,
    input logic             sd_ras_n,
    input logic             sd_cas_n,
    input logic             sd_we_n,
    input logic [ROW_W-1:0] sd_addr,
    input logic             sd_dq_oe
);

    localparam int GAP_W = $clog2(T_RP + T_RCD + 4) + 1;
    localparam int VC_W  = $clog2(BURST) + 2;

    logic [3:0] pin_v;
    logic       is_nop, is_pre, is_act, is_col;
    logic [GAP_W-1:0] since_pre, since_act;
    logic [VC_W-1:0]  vrun;

    assign pin_v  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_nop = (pin_v == 4'b0111);
    assign is_pre = (pin_v == 4'b0010);
    assign is_act = (pin_v == 4'b0011);
    assign is_col = (pin_v == 4'b0101) || (pin_v == 4'b0100);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_pre <= '1;
            since_act <= '1;
            vrun      <= '0;
        end else begin
            if (is_pre)               since_pre <= GAP_W'(1);
            else if (since_pre != '1) since_pre <= since_pre + 1'b1;
            if (is_act)               since_act <= GAP_W'(1);
            else if (since_act != '1) since_act <= since_act + 1'b1;
            vrun <= rd_valid ? vrun + 1'b1 : '0;
        end
    end

    // R10
    legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_nop || is_pre || is_act || is_col);

    // R1
    idle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> is_nop);

    // R2
    first_cmd_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> is_pre);

    // R3
    pre_all_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> sd_addr[10]);

    // R3
    trp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> (since_pre == GAP_W'(T_RP)));

    // R4
    trcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (since_act == GAP_W'(T_RCD)));

    // R5
    col_autopre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> sd_addr[10]);

    // R8
    oe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> busy);

    // R7
    done_after_eight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> (rd_valid && vrun == VC_W'(BURST - 1)));

endmodule

bind sdram_burst_seq sbs_chk #(
    .ROW_W (ROW_W),
    .BURST (BURST),
    .T_RP  (T_RP),
    .T_RCD (T_RCD)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .rd_valid (rd_valid),
    .rd_done  (rd_done),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_addr  (sd_addr),
    .sd_dq_oe (sd_dq_oe)
);

// File: tb/sdram_burst_seq_tb.sv
module sdram_burst_seq_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [1:0]   req_bank = '0;
    logic [12:0]  req_row = '0;
    logic [8:0]   req_col = '0;
    logic [127:0] req_wdata = '0;
    logic         busy, rd_valid, rd_done;
    logic [15:0]  rd_data;
    logic         sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]   sd_ba;
    logic [12:0]  sd_addr;
    logic [15:0]  sd_dq_out;
    logic         sd_dq_oe;
    logic [15:0]  sd_dq_in = '0;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sdram_burst_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .rd_done(rd_done),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .sd_dq_in(sd_dq_in)
    );

    function automatic logic [15:0] dflt_word(logic [1:0] b, logic [12:0] r, logic [8:0] c);
        return {b, r[4:0], c} ^ 16'hA5C3;
    endfunction

    function automatic logic [15:0] seed_word(logic [7:0] s, int k);
        return {s, 5'(k), 3'b101};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural device model ----------------
    logic [15:0] mem [bit [23:0]];
    int          since_pre = 99, since_act = 99;
    int          model_err = 0;
    int          act_count = 0;
    logic [1:0]  open_bank, col_bank;
    logic [12:0] open_row;
    logic [8:0]  last_col;
    bit          last_wr;
    int          rd_phase = -1, wr_phase = -1;
    logic [23:0] burst_key;

    always @(posedge clk) begin
        logic [3:0] p;
        p = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        since_pre = since_pre + 1;
        since_act = since_act + 1;
        if (rd_phase >= 0) begin
            logic [23:0] k2;
            k2 = burst_key + 24'(rd_phase);
            sd_dq_in <= mem.exists(k2) ? mem[k2] : dflt_word(k2[23:22], k2[21:9], k2[8:0]);
            rd_phase = (rd_phase == 7) ? -1 : rd_phase + 1;
        end
        if (wr_phase >= 0) begin
            mem[burst_key + 24'(wr_phase)] = sd_dq_out;
            if (!sd_dq_oe) model_err++;
            wr_phase = (wr_phase == 7) ? -1 : wr_phase + 1;
        end
        if (rst_n) begin
            case (p)
                4'b0010: begin
                    if (!sd_addr[10]) model_err++;
                    since_pre = 0;
                end
                4'b0011: begin
                    if (since_pre != 3) model_err++;
                    since_act = 0; act_count++;
                    open_bank = sd_ba; open_row = sd_addr;
                end
                4'b0101, 4'b0100: begin
                    if (since_act != 10 || !sd_addr[10] || sd_ba != open_bank) model_err++;
                    last_col = sd_addr[8:0];
                    col_bank = sd_ba;
                    last_wr  = (p == 4'b0100);
                    burst_key = {sd_ba, open_row, sd_addr[8:0]};
                    if (last_wr) begin
                        mem[burst_key] = sd_dq_out;
                        wr_phase = 1;
                    end else begin
                        rd_phase = 0;
                    end
                end
                4'b0111: ;
                default: model_err++;
            endcase
        end
    end

    // ---------------- vector table: {wr, bank, row, col, seed} ----------------
    localparam logic [32:0] VEC [0:7] = '{
        {1'b1, 2'd1, 13'd100,  9'd8,   8'h11},
        {1'b0, 2'd1, 13'd100,  9'd8,   8'h11},
        {1'b1, 2'd3, 13'd8191, 9'd504, 8'h5A},
        {1'b0, 2'd0, 13'd77,   9'd16,  8'h00},
        {1'b0, 2'd3, 13'd8191, 9'd504, 8'h5A},
        {1'b1, 2'd1, 13'd100,  9'd8,   8'h22},
        {1'b0, 2'd1, 13'd100,  9'd8,   8'h22},
        {1'b0, 2'd2, 13'd0,    9'd0,   8'h00}
    };

    task automatic run_access(input logic [32:0] v, input bit intrude);
        bit          wr;
        logic [1:0]  b;
        logic [12:0] r;
        logic [8:0]  c;
        logic [7:0]  s;
        int nbusy = 0, nv = 0, nw = 0, acts0, errs0;
        wr = v[32]; b = v[31:30]; r = v[29:17]; c = v[16:8]; s = v[7:0];
        acts0 = act_count; errs0 = model_err;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_bank = b; req_row = r; req_col = c;
        for (int k = 0; k < 8; k++) req_wdata[16*k +: 16] = seed_word(s, k);
        @(posedge clk);
        for (int k = 1; k <= 27; k++) begin
            @(negedge clk);
            if (k == 1) begin
                req_valid = 1'b0;
                check(busy == 1'b1, "R2 busy after accept", busy, 1);
            end
            if (intrude && k == 5) begin
                req_valid = 1'b1; req_bank = 2'd2; req_row = 13'd4321; req_col = 9'd64;
            end
            if (intrude && k == 6) req_valid = 1'b0;
            if (busy) nbusy++;
            if (sd_dq_oe) begin
                check(k == 14 + nw, "R8 write beat cycle", k, 14 + nw);
                check(sd_dq_out == seed_word(s, nw), "R8 write beat data", sd_dq_out, seed_word(s, nw));
                nw++;
            end
            if (rd_valid) begin
                logic [15:0] e;
                e = (s != 0) ? seed_word(s, nv) : dflt_word(b, r, c + 9'(nv));
                check(k == 17 + nv, "R7 read word cycle", k, 17 + nv);
                check(rd_data == e, "R6 read word data", rd_data, e);
                check(rd_done == (nv == 7), "R7 done with eighth word", rd_done, nv == 7);
                nv++;
            end
        end
        check(nbusy == (wr ? 21 : 23), "R9 busy length", nbusy, wr ? 21 : 23);
        check((wr ? nw : nv) == 8, "R7/R8 beat count", wr ? nw : nv, 8);
        check(model_err == errs0, "R3/R4 command spacing and A10", model_err - errs0, 0);
        check(act_count == acts0 + 1, "R2 single activate", act_count - acts0, 1);
        check(open_bank == b && open_row == r, "R4 activate bank/row", {open_bank, open_row}, {b, r});
        check(last_col == c && col_bank == b, "R5 column address", last_col, c);
        check(last_wr == wr, "R5 column command type", last_wr, wr);
    endtask

    task automatic run_all();
        // R1: reset state, with a request presented while in reset
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 NOP in reset",
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
        check(sd_dq_oe == 1'b0 && rd_valid == 1'b0, "R1 oe/valid in reset", {sd_dq_oe, rd_valid}, 0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy == 1'b0, "R1 idle after reset", busy, 0);

        foreach (VEC[i]) run_access(VEC[i], 1'b0);

        // R2: intruding request during a busy read is dropped
        run_access({1'b0, 2'd0, 13'd555, 9'd32, 8'h00}, 1'b1);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R2 intruder not accepted", busy, 0);

        // R10: idle again drives NOP
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R10 NOP when idle",
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
        check(model_err == 0, "R10 only legal commands", model_err, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule